// File: doc/BRIEF.md
# Sleep and Standby Power-Down Controller

This block decides what happens when a processor core executes its halt-and-wait instruction. One control bit picks the low-power depth. With the bit clear, the core only stops, and the system clock keeps running. With the bit set, the system clock enable drops as well. An external interrupt brings the core back. From the shallow state the return is immediate. From the deep state the clock enable stays low for an oscillator-settling interval picked by a 3-bit code. The clock enable and a one-cycle resume strobe then rise together.

Software reaches the block through an 8-bit register with a write strobe and an always-visible read value. The core supplies a one-cycle sleep request and a level interrupt line that it has already masked. The clock enable drives the chip's clock gate, and the halt output freezes the core.

The settling intervals are powers of two. Their base exponents are parameters, `BASE_LOG2` (default 13) and `SHORT_LOG2` (default 10), so a test build can shrink them.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released: `reg_rdata` reads 0x00, `clk_en` is 1, `core_halt` is 0 and `resume` is 0.
- R2: The control register layout is as follows. Bit 7 is the deep-select bit. Bits 6:4 are the wait code. Bit 0 reads back the illegal-code flag. Bits 3:1 read 0 and ignore writes. A write (`reg_wr`=1) stores bits 7:4 on the next clock edge.
- R3: In the running state, `sleep_req` with deep-select 0 raises `core_halt` from the next edge. `clk_en` stays 1.
- R4: In the shallow state, `irq` sampled high at an edge returns to running at that edge. `core_halt` falls and `resume` rises together, with no settling wait.
- R5: In the running state, `sleep_req` with deep-select 1 takes `clk_en` low and `core_halt` high from the next edge.
- R6: In the deep state, the edge that samples `irq` high starts a wait of N cycles. `clk_en` then stays 0 for N further edges. It rises on the (N+1)-th edge counted from and including the taking edge, in the same cycle as `resume`.
- R7: Wait codes 0 to 5 give N = 2^(BASE_LOG2+code). With the defaults these are 8192, 16384, 32768, 65536, 131072 and 262144. Code 6 gives N = 2^SHORT_LOG2 (1024 by default).
- R8: Code 7 is illegal. It uses the longest wait, 2^(BASE_LOG2+5), and a write carrying it sets flag bit 0. The flag stays set through later writes. It clears only on a write with bit 0 = 1 that does not carry code 7.
- R9: Deep-select stays 1 after a deep wake-up. Only a register write changes it.
- R10: `sleep_req` has no effect in the shallow, deep or settling states. `irq` has no effect in the running and settling states.
- R11: `resume` is high for exactly one cycle per wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register read value |
| sleep_req | input | 1 | One-cycle halt request from the core |
| irq | input | 1 | Unmasked external interrupt request (level) |
| core_halt | output | 1 | High while the core must stay stopped |
| clk_en | output | 1 | System clock gate enable |
| resume | output | 1 | One-cycle wake-up strobe |

## Verification
The hardest case to reach is a second interrupt, or a sleep request, that arrives while the settling counter is still running. Both must leave the countdown and the wake-up edge untouched. The bench gets there by taking the first interrupt in the deep state and counting edges. Two cycles later it raises `irq` and `sleep_req` together, while `clk_en` is still low. It then checks that the rise of `clk_en` and `resume` still lands exactly N+1 edges after the taking edge, for every wait code including the illegal one.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [1:0] {
    PD_RUN    = 2'd0,
    PD_NAP    = 2'd1,
    PD_DEEP   = 2'd2,
    PD_SETTLE = 2'd3
  } pd_state_e;

  localparam int unsigned REG_W        = 8;
  localparam int unsigned CTL_DEEP_BIT = 7;
  localparam int unsigned CTL_WSEL_LSB = 4;
  localparam int unsigned CTL_FLAG_BIT = 0;
  localparam int unsigned WSEL_W       = 3;
  localparam int unsigned NUM_CODES    = 1 << WSEL_W;
  localparam int unsigned NUM_LONG     = 6;

  localparam logic [WSEL_W-1:0] WSEL_SHORT = 3'b110;
  localparam logic [WSEL_W-1:0] WSEL_BAD   = 3'b111;
endpackage

// File: rtl/pwrdn_regs.sv
module pwrdn_regs
  import pwrdn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  output logic              deep_sel,
  output logic [WSEL_W-1:0] wsel,
  output logic              bad_flag,
  output logic [REG_W-1:0]  rdata
);
  logic [WSEL_W-1:0] wr_code;
  logic              unused_wbits;

  assign wr_code      = wdata[CTL_WSEL_LSB +: WSEL_W];
  assign unused_wbits = ^wdata[CTL_WSEL_LSB-1:CTL_FLAG_BIT+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deep_sel <= 1'b0;
      wsel     <= '0;
      bad_flag <= 1'b0;
    end else if (wr_en) begin
      deep_sel <= wdata[CTL_DEEP_BIT];
      wsel     <= wr_code;
      if (wr_code == WSEL_BAD)
        bad_flag <= 1'b1;
      else if (wdata[CTL_FLAG_BIT])
        bad_flag <= 1'b0;
    end
  end

  always_comb begin
    rdata                              = '0;
    rdata[CTL_DEEP_BIT]                = deep_sel;
    rdata[CTL_WSEL_LSB +: WSEL_W]      = wsel;
    rdata[CTL_FLAG_BIT]                = bad_flag;
  end

  // R8: the flag survives any write that does not request clearing
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_flag && !(wr_en && wdata[CTL_FLAG_BIT]) |=> bad_flag);

  // R9: deep-select moves only on a write
  assert_deep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(deep_sel));
endmodule

// File: rtl/pwrdn_settle.sv
module pwrdn_settle
  import pwrdn_pkg::*;
#(
  parameter int BASE_LOG2  = 13,
  parameter int SHORT_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WSEL_W-1:0] wsel,
  output logic              done
);
  localparam int CNT_W    = BASE_LOG2 + NUM_LONG - 1;
  localparam int LONG_EXP = BASE_LOG2 + NUM_LONG - 1;

  logic [CNT_W-1:0] reload_tbl [NUM_CODES];
  logic [CNT_W-1:0] cnt;
  logic             busy;

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_tbl
    if (c < NUM_LONG) begin : g_long
      assign reload_tbl[c] = CNT_W'((64'd1 << (BASE_LOG2 + c)) - 64'd1);
    end else if (c == int'(WSEL_SHORT)) begin : g_short
      assign reload_tbl[c] = CNT_W'((64'd1 << SHORT_LOG2) - 64'd1);
    end else begin : g_bad
      assign reload_tbl[c] = CNT_W'((64'd1 << LONG_EXP) - 64'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      cnt  <= reload_tbl[wsel];
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0)
        busy <= 1'b0;
      else
        cnt <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  // R6: the settling count steps down by one each cycle
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt != '0) && !load |=> busy && (cnt == $past(cnt) - 1'b1));

  // R11: terminal count lasts one cycle
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
  import pwrdn_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      irq,
  input  logic      deep_sel,
  input  logic      settle_done,
  output pd_state_e state,
  output logic      settle_load,
  output logic      resume
);
  pd_state_e nxt;
  logic      wake;

  always_comb begin
    nxt         = state;
    settle_load = 1'b0;
    wake        = 1'b0;
    unique case (state)
      PD_RUN:    if (sleep_req) nxt = deep_sel ? PD_DEEP : PD_NAP;
      PD_NAP:    if (irq) begin nxt = PD_RUN; wake = 1'b1; end
      PD_DEEP:   if (irq) begin nxt = PD_SETTLE; settle_load = 1'b1; end
      PD_SETTLE: if (settle_done) begin nxt = PD_RUN; wake = 1'b1; end
      default:   nxt = PD_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= PD_RUN;
      resume <= 1'b0;
    end else begin
      state  <= nxt;
      resume <= wake;
    end
  end

  // R10: the shallow state holds until an interrupt, whatever sleep_req does
  assert_nap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PD_NAP) && !irq |=> (state == PD_NAP));

  // R10: the deep state holds until an interrupt
  assert_deep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PD_DEEP) && !irq |=> (state == PD_DEEP));

  // R11: resume is a single-cycle strobe
  assert_resume_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  // R4: a shallow wake-up takes one edge
  assert_nap_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PD_NAP) && irq |=> (state == PD_RUN) && resume);
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int BASE_LOG2  = 13,
  parameter int SHORT_LOG2 = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sleep_req,
  input  logic       irq,
  output logic       core_halt,
  output logic       clk_en,
  output logic       resume
);
  logic              deep_sel;
  logic [WSEL_W-1:0] wsel;
  logic              bad_flag;
  logic              settle_load;
  logic              settle_done;
  pd_state_e         state;

  pwrdn_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wdata    (reg_wdata),
    .deep_sel (deep_sel),
    .wsel     (wsel),
    .bad_flag (bad_flag),
    .rdata    (reg_rdata)
  );

  pwrdn_settle #(
    .BASE_LOG2  (BASE_LOG2),
    .SHORT_LOG2 (SHORT_LOG2)
  ) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (settle_load),
    .wsel  (wsel),
    .done  (settle_done)
  );

  pwrdn_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .irq         (irq),
    .deep_sel    (deep_sel),
    .settle_done (settle_done),
    .state       (state),
    .settle_load (settle_load),
    .resume      (resume)
  );

  assign core_halt = (state != PD_RUN);
  assign clk_en    = (state != PD_DEEP) && (state != PD_SETTLE);

  // R6: the clock comes back only together with the resume strobe
  assert_clken_with_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> resume);

  // R3: halting starts only from a sleep request
  assert_halt_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_halt) |-> $past(sleep_req));

  // R5: the gate closes only while halted
  assert_gate_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> core_halt);
endmodule

// File: tb/test_pwrdn_ctrl.sv
`timescale 1ns/1ps
module test_pwrdn_ctrl;
  localparam int BL = 4;
  localparam int SL = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sleep_req = 1'b0;
  logic       irq = 1'b0;
  logic       core_halt;
  logic       clk_en;
  logic       resume;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  pwrdn_ctrl #(.BASE_LOG2(BL), .SHORT_LOG2(SL)) i_pwrdn_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sleep_req (sleep_req),
    .irq       (irq),
    .core_halt (core_halt),
    .clk_en    (clk_en),
    .resume    (resume)
  );

  function automatic int exp_wait(input int code);
    if (code < 6) return 1 << (BL + code);
    if (code == 6) return 1 << SL;
    return 1 << (BL + 5);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rdata in reset", reg_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 core_halt", core_halt, 0);
    chk("R1 resume", resume, 0);
  endtask

  task automatic t_regs();
    wr(8'hDE);
    chk("R2 layout 0xDE", reg_rdata, 8'hD0);
    wr(8'h2E);
    chk("R2 layout 0x2E", reg_rdata, 8'h20);
    wr(8'h00);
    chk("R2 cleared", reg_rdata, 0);
  endtask

  task automatic t_nap();
    wr(8'h00);
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    chk("R3 core_halt", core_halt, 1);
    chk("R3 clk_en", clk_en, 1);
    chk("R3 resume", resume, 0);
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    chk("R10 sleep_req in nap", core_halt, 1);
    chk("R10 sleep_req in nap resume", resume, 0);
    irq = 1'b1;
    @(posedge clk); #1;
    chk("R4 resume", resume, 1);
    chk("R4 core_halt", core_halt, 0);
    irq = 1'b0;
    @(posedge clk); #1;
    chk("R11 nap resume width", resume, 0);
  endtask

  task automatic t_deep(input int code);
    int n;
    int lowok;
    n = 0;
    lowok = 1;
    wr({1'b1, code[2:0], 4'b0000});
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    chk("R5 clk_en", clk_en, 0);
    chk("R5 core_halt", core_halt, 1);
    repeat (2) @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    chk("R10 sleep_req in deep", clk_en, 0);
    irq = 1'b1;
    while (n < 4000) begin
      @(posedge clk); #1;
      n++;
      if (n == 1) irq = 1'b0;
      if (n == 2) begin irq = 1'b1; sleep_req = 1'b1; end
      if (n == 3) begin irq = 1'b0; sleep_req = 1'b0; end
      if (resume) break;
      if (clk_en) lowok = 0;
    end
    $display("code %0d: wake after %0d edges", code, n);
    chk("R6 R7 R10 wake edge count", n, exp_wait(code) + 1);
    chk("R6 clk_en with resume", clk_en, 1);
    chk("R6 clk_en low during wait", lowok, 1);
    @(posedge clk); #1;
    chk("R11 deep resume width", resume, 0);
    chk("R9 deep-select kept", reg_rdata[7], 1);
    irq = 1'b1;
    @(posedge clk); #1;
    irq = 1'b0;
    chk("R10 irq in run resume", resume, 0);
    chk("R10 irq in run halt", core_halt, 0);
    wr(8'h00);
    chk("R9 deep-select write", reg_rdata[7], 0);
  endtask

  task automatic t_bad();
    wr(8'h70);
    chk("R8 flag set", reg_rdata, 8'h71);
    wr(8'h00);
    chk("R8 flag sticky", reg_rdata, 8'h01);
    wr(8'h71);
    chk("R8 set beats clear", reg_rdata, 8'h71);
    wr(8'h01);
    chk("R8 flag cleared", reg_rdata, 8'h00);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_nap();
    for (int c = 0; c < 8; c++) t_deep(c);
    t_bad();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule